// File: doc/BRIEF.md
# Serial Interrupt Stream Decoder

This block listens to a shared, active-low serial interrupt line that is sampled on the bus clock. It waits for the line to rest high. It then recognises a start frame as a run of low clocks of bounded length. It counts clocks from the end of that run and captures the line once in each of 21 three-clock data frames. Each captured slot is bound to an interrupt number, a system-management request, a channel-check event or one of four shared PCI interrupt pins.

The decoded interrupt levels stay in registers from one serial cycle to the next. Each level is combined by logical AND with the on-chip active-low source of the same number before it reaches the interrupt controller. The system-management slot gives a one-clock request pulse and a sticky status flag that software clears. The channel-check slot gives a one-clock event. The two keyboard-related slots are also brought out raw, before the merge. A short low pulse after the last data frame selects the line's operating mode, and the block reports that mode.

Top module: `sirq_decoder`

## Requirements
- R1: A start frame is accepted only after the line has been seen high, then held low for at least 4 and at most 8 consecutive clocks, then seen high again. A low run of 3 clocks or of 9 or more clocks is discarded and changes no output.
- R2: The first high clock after an accepted start run is clock 0. Data frame n (1 to 21) is captured from the line value at clock 2 + 3·(n−1). The other two clocks of each frame are not captured.
- R3: Frame 2 sets IRQ1. Frames 4 to 16 set IRQ3 to IRQ15 in turn. Frames 18 to 21 set `pci_int_n[0]` to `pci_int_n[3]` (pins A to D). Exactly one slot lands in each destination.
- R4: Frames 1, 9, 14 and 15 (IRQ0, IRQ8, IRQ13, IRQ14) are discarded, and IRQ2 has no slot. For these five lines `irq_n[i]` always equals `int_irq_n[i]`.
- R5: A low capture in frame 3 raises `smi_req` for exactly one clock, in the clock after the capture edge, and sets `smi_sts` at that same edge. `smi_sts` stays set until a clock with `smi_sts_clr` high. A capture and a clear at the same edge leave it set.
- R6: A low capture in frame 17 raises `iochk_evt` for exactly one clock after the capture edge. A high capture raises nothing.
- R7: Each `irq_n[i]` is the AND of `int_irq_n[i]` and the held serial level for line i. Each `pci_int_n[j]` is the AND of `int_pci_n[j]` and the held serial level for pin j. A low internal source therefore always gives a low output.
- R8: `kbd_irq1_n` and `kbd_irq12_n` carry the held serial levels of IRQ1 and IRQ12 without the merge, so they do not follow `int_irq_n`.
- R9: After frame 21 (clock 64), a stop pulse of 2 low clocks sets `cont_mode` to 0 (quiet mode). A stop pulse of 3 low clocks sets it to 1 (continuous mode). A pulse of any other length leaves it unchanged.
- R10: Reset sets every held serial level high, clears `smi_sts`, `smi_req` and `iochk_evt`, and sets `cont_mode` to 1. Held levels keep their value between serial cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serirq_n | input | 1 | Serial interrupt line, active low |
| int_irq_n | input | 16 | Internal active-low interrupt sources, indexed by IRQ number |
| int_pci_n | input | 4 | Internal active-low PCI interrupt sources, pins A to D |
| smi_sts_clr | input | 1 | Clears the system-management status flag |
| irq_n | output | 16 | Merged active-low interrupt levels, indexed by IRQ number |
| pci_int_n | output | 4 | Merged active-low PCI interrupt levels, pins A to D |
| kbd_irq1_n | output | 1 | Raw held serial level of IRQ1, before the merge |
| kbd_irq12_n | output | 1 | Raw held serial level of IRQ12, before the merge |
| smi_req | output | 1 | One-clock system-management request |
| smi_sts | output | 1 | Sticky system-management status flag |
| iochk_evt | output | 1 | One-clock channel-check event |
| cont_mode | output | 1 | 1 = continuous mode, 0 = quiet mode |

## Verification
The bench builds the block with its default timing parameters: three-clock frames, a first capture two clocks after the start run, and a start run of 4 to 8 clocks. With these values both ends of the start-length window, the rejected lengths 3 and 9, all three stop-pulse outcomes and the full 21-slot cycle fit into a few hundred clocks. This lets each serial cycle cover the discarded slots, the system-management and channel-check slots and the merge with low internal sources. A clear held through a capture shows that the set takes priority, and consecutive cycles carry opposite values so that the capture clock of a slot is pinned down exactly.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NUM_SLOTS = 21;
    localparam int NUM_IRQ   = 16;
    localparam int NUM_PCI   = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);

    // Slot positions whose meaning other logic decodes
    localparam int SMI_SLOT  = 2;
    localparam int CHK_SLOT  = 16;
    localparam int PCI_SLOT0 = 17;

    // Stop pulse lengths that pick the operating mode
    localparam int QUIET_LEN = 2;
    localparam int CONT_LEN  = 3;

    typedef enum logic [2:0] {
        FS_WAIT_HIGH,
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_STOP
    } frame_state_e;

    typedef enum logic {
        MODE_QUIET = 1'b0,
        MODE_CONT  = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        logic              level_n;
    } slot_sample_t;

    // An IRQ line takes a serial level only when its slot is honoured
    function automatic logic irq_slot_live(input int irq);
        return !(irq == 0 || irq == 2 || irq == 8 || irq == 13 || irq == 14);
    endfunction

    // Zero-based slot index for an IRQ number that has a slot
    function automatic int irq_to_slot(input int irq);
        return irq;
    endfunction

endpackage

// File: rtl/sirq_framer.sv
module sirq_framer
    import sirq_pkg::*;
#(
    parameter int FRAME_CLKS   = 3,
    parameter int FIRST_SAMPLE = 2,
    parameter int START_MIN    = 4,
    parameter int START_MAX    = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_n,
    output slot_sample_t smp,
    output line_mode_e   mode
);

    localparam int PH_W     = $clog2(FRAME_CLKS);
    localparam int LOW_W    = $clog2(START_MAX + 1);
    localparam int LAST_PH  = FRAME_CLKS - 1;
    localparam int ENTRY_PH = (FRAME_CLKS - FIRST_SAMPLE + 1) % FRAME_CLKS;

    frame_state_e      state;
    logic [LOW_W-1:0]  low_cnt;
    logic [PH_W-1:0]   phase;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        smp.valid   = (state == FS_DATA) && (phase == '0);
        smp.slot    = slot;
        smp.level_n = line_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_WAIT_HIGH;
            low_cnt <= '0;
            phase   <= '0;
            slot    <= '0;
            mode    <= MODE_CONT;
        end else begin
            case (state)
                FS_WAIT_HIGH: begin
                    if (line_n) state <= FS_IDLE;
                end
                FS_IDLE: begin
                    if (!line_n) begin
                        state   <= FS_START;
                        low_cnt <= LOW_W'(1);
                    end
                end
                FS_START: begin
                    if (!line_n) begin
                        if (low_cnt == LOW_W'(START_MAX)) state <= FS_WAIT_HIGH;
                        else low_cnt <= low_cnt + 1'b1;
                    end else if (low_cnt >= LOW_W'(START_MIN)) begin
                        state <= FS_DATA;
                        phase <= PH_W'(ENTRY_PH);
                        slot  <= '0;
                    end else begin
                        state <= FS_IDLE;
                    end
                end
                FS_DATA: begin
                    if (phase == PH_W'(LAST_PH)) phase <= '0;
                    else phase <= phase + 1'b1;
                    if (phase == '0) slot <= slot + 1'b1;
                    if (phase == PH_W'(LAST_PH) && slot == SLOT_W'(NUM_SLOTS)) begin
                        state   <= FS_STOP;
                        low_cnt <= '0;
                    end
                end
                FS_STOP: begin
                    if (!line_n) begin
                        // A long low run after the data frames is a fresh start
                        if (low_cnt == LOW_W'(START_MIN - 1)) state <= FS_START;
                        low_cnt <= low_cnt + 1'b1;
                    end else if (low_cnt != '0) begin
                        if (low_cnt == LOW_W'(QUIET_LEN)) mode <= MODE_QUIET;
                        else if (low_cnt == LOW_W'(CONT_LEN)) mode <= MODE_CONT;
                        state <= FS_IDLE;
                    end
                end
                default: state <= FS_WAIT_HIGH;
            endcase
        end
    end

endmodule

// File: rtl/sirq_slot_bank.sv
module sirq_slot_bank
    import sirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  slot_sample_t       smp,
    output logic [NUM_IRQ-1:0] irq_lvl_n,
    output logic [NUM_PCI-1:0] pci_lvl_n
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        if (irq_slot_live(i)) begin : g_live
            logic lvl_q;
            always_ff @(posedge clk) begin
                if (rst) lvl_q <= 1'b1;
                else if (smp.valid && smp.slot == SLOT_W'(irq_to_slot(i)))
                    lvl_q <= smp.level_n;
            end
            assign irq_lvl_n[i] = lvl_q;
        end else begin : g_dead
            // Source exists only on chip; the serial slot never reaches it
            assign irq_lvl_n[i] = 1'b1;
        end
    end

    for (genvar j = 0; j < NUM_PCI; j++) begin : g_pci
        logic lvl_q;
        always_ff @(posedge clk) begin
            if (rst) lvl_q <= 1'b1;
            else if (smp.valid && smp.slot == SLOT_W'(PCI_SLOT0 + j))
                lvl_q <= smp.level_n;
        end
        assign pci_lvl_n[j] = lvl_q;
    end

endmodule

// File: rtl/sirq_event_unit.sv
module sirq_event_unit
    import sirq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  slot_sample_t smp,
    input  logic         sts_clr,
    output logic         smi_req,
    output logic         smi_sts,
    output logic         chk_evt
);

    logic smi_hit;
    logic chk_hit;

    assign smi_hit = smp.valid && (smp.slot == SLOT_W'(SMI_SLOT)) && !smp.level_n;
    assign chk_hit = smp.valid && (smp.slot == SLOT_W'(CHK_SLOT)) && !smp.level_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req <= 1'b0;
            smi_sts <= 1'b0;
            chk_evt <= 1'b0;
        end else begin
            smi_req <= smi_hit;
            chk_evt <= chk_hit;
            if (smi_hit) smi_sts <= 1'b1;
            else if (sts_clr) smi_sts <= 1'b0;
        end
    end

endmodule

// File: rtl/sirq_merge.sv
module sirq_merge
    import sirq_pkg::*;
(
    input  logic [NUM_IRQ-1:0] ser_irq_n,
    input  logic [NUM_IRQ-1:0] int_irq_n,
    input  logic [NUM_PCI-1:0] ser_pci_n,
    input  logic [NUM_PCI-1:0] int_pci_n,
    output logic [NUM_IRQ-1:0] irq_n,
    output logic [NUM_PCI-1:0] pci_n
);

    always_comb begin
        irq_n = ser_irq_n & int_irq_n;
        pci_n = ser_pci_n & int_pci_n;
    end

endmodule

// File: rtl/sirq_decoder.sv
module sirq_decoder
    import sirq_pkg::*;
#(
    parameter int FRAME_CLKS   = 3,
    parameter int FIRST_SAMPLE = 2,
    parameter int START_MIN    = 4,
    parameter int START_MAX    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        serirq_n,
    input  logic [15:0] int_irq_n,
    input  logic [3:0]  int_pci_n,
    input  logic        smi_sts_clr,
    output logic [15:0] irq_n,
    output logic [3:0]  pci_int_n,
    output logic        kbd_irq1_n,
    output logic        kbd_irq12_n,
    output logic        smi_req,
    output logic        smi_sts,
    output logic        iochk_evt,
    output logic        cont_mode
);

    slot_sample_t       smp;
    line_mode_e         mode;
    logic [NUM_IRQ-1:0] irq_lvl_n;
    logic [NUM_PCI-1:0] pci_lvl_n;

    sirq_framer #(
        .FRAME_CLKS  (FRAME_CLKS),
        .FIRST_SAMPLE(FIRST_SAMPLE),
        .START_MIN   (START_MIN),
        .START_MAX   (START_MAX)
    ) u_framer (
        .clk   (clk),
        .rst   (rst),
        .line_n(serirq_n),
        .smp   (smp),
        .mode  (mode)
    );

    sirq_slot_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .irq_lvl_n(irq_lvl_n),
        .pci_lvl_n(pci_lvl_n)
    );

    sirq_event_unit u_events (
        .clk    (clk),
        .rst    (rst),
        .smp    (smp),
        .sts_clr(smi_sts_clr),
        .smi_req(smi_req),
        .smi_sts(smi_sts),
        .chk_evt(iochk_evt)
    );

    sirq_merge u_merge (
        .ser_irq_n(irq_lvl_n),
        .int_irq_n(int_irq_n),
        .ser_pci_n(pci_lvl_n),
        .int_pci_n(int_pci_n),
        .irq_n    (irq_n),
        .pci_n    (pci_int_n)
    );

    assign kbd_irq1_n  = irq_lvl_n[1];
    assign kbd_irq12_n = irq_lvl_n[12];
    assign cont_mode   = (mode == MODE_CONT);

endmodule

// File: rtl/sirq_decoder_chk.sv
module sirq_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] int_irq_n,
    input logic [3:0]  int_pci_n,
    input logic        smi_sts_clr,
    input logic [15:0] irq_n,
    input logic [3:0]  pci_int_n,
    input logic        kbd_irq1_n,
    input logic        kbd_irq12_n,
    input logic        smi_req,
    input logic        smi_sts,
    input logic        iochk_evt
);

    AST_IGNORED_PASS: assert property (@(posedge clk) disable iff (rst)
        irq_n[0] == int_irq_n[0] && irq_n[2] == int_irq_n[2] && irq_n[8] == int_irq_n[8] &&
        irq_n[13] == int_irq_n[13] && irq_n[14] == int_irq_n[14]); // R4

    AST_MERGE_LOW: assert property (@(posedge clk) disable iff (rst)
        ((~int_irq_n & irq_n) == 16'h0) && ((~int_pci_n & pci_int_n) == 4'h0)); // R7

    AST_KBD1_AHEAD: assert property (@(posedge clk) disable iff (rst)
        !kbd_irq1_n |-> !irq_n[1]); // R8

    AST_KBD12_AHEAD: assert property (@(posedge clk) disable iff (rst)
        !kbd_irq12_n |-> !irq_n[12]); // R8

    AST_SMI_SETS_STS: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> smi_sts); // R5

    AST_SMI_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> !smi_req); // R5

    AST_SMI_STICKY: assert property (@(posedge clk) disable iff (rst)
        (smi_sts && !smi_sts_clr) |=> smi_sts); // R5

    AST_CHK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        iochk_evt |=> !iochk_evt); // R6

    AST_EVENTS_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smi_req, iochk_evt})); // R3

endmodule

bind sirq_decoder sirq_decoder_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .int_irq_n  (int_irq_n),
    .int_pci_n  (int_pci_n),
    .smi_sts_clr(smi_sts_clr),
    .irq_n      (irq_n),
    .pci_int_n  (pci_int_n),
    .kbd_irq1_n (kbd_irq1_n),
    .kbd_irq12_n(kbd_irq12_n),
    .smi_req    (smi_req),
    .smi_sts    (smi_sts),
    .iochk_evt  (iochk_evt)
);

// File: tb/test_sirq_decoder.sv
module test_sirq_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        serirq_n = 1'b1;
    logic [15:0] int_irq_n = '1;
    logic [3:0]  int_pci_n = '1;
    logic        smi_sts_clr = 1'b0;
    logic [15:0] irq_n;
    logic [3:0]  pci_int_n;
    logic        kbd_irq1_n, kbd_irq12_n, smi_req, smi_sts, iochk_evt, cont_mode;

    always #2 clk = ~clk;

    sirq_decoder i_sirq_decoder (
        .clk(clk), .rst(rst), .serirq_n(serirq_n), .int_irq_n(int_irq_n),
        .int_pci_n(int_pci_n), .smi_sts_clr(smi_sts_clr), .irq_n(irq_n),
        .pci_int_n(pci_int_n), .kbd_irq1_n(kbd_irq1_n), .kbd_irq12_n(kbd_irq12_n),
        .smi_req(smi_req), .smi_sts(smi_sts), .iochk_evt(iochk_evt), .cont_mode(cont_mode)
    );

    int errors = 0;
    int checks = 0;

    // Reference state: serial levels by IRQ number and PCI pin, events, mode
    logic [15:0] m_irq = '1;
    logic [3:0]  m_pci = '1;
    logic        m_req = 1'b0, m_sts = 1'b0, m_chk = 1'b0, m_mode = 1'b1;
    bit          cmp_on = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(irq_n === (int_irq_n & m_irq), "R7 irq_n", 32'(irq_n), 32'(int_irq_n & m_irq));
            check(pci_int_n === (int_pci_n & m_pci), "R3 pci_int_n", 32'(pci_int_n), 32'(int_pci_n & m_pci));
            check({kbd_irq12_n, kbd_irq1_n} === {m_irq[12], m_irq[1]}, "R8 kbd",
                  32'({kbd_irq12_n, kbd_irq1_n}), 32'({m_irq[12], m_irq[1]}));
            check(smi_req === m_req, "R5 smi_req", 32'(smi_req), 32'(m_req));
            check(smi_sts === m_sts, "R5 smi_sts", 32'(smi_sts), 32'(m_sts));
            check(iochk_evt === m_chk, "R6 iochk_evt", 32'(iochk_evt), 32'(m_chk));
            check(cont_mode === m_mode, "R9 cont_mode", 32'(cont_mode), 32'(m_mode));
        end
    end

    // Drive one clock of the line; fr is the frame index captured there (or -1)
    task automatic tick(input logic v, input int fr, input int md);
        bit set;
        serirq_n = v;
        @(posedge clk);
        #1;
        set   = 1'b0;
        m_req = 1'b0;
        m_chk = 1'b0;
        if (fr >= 0) begin
            if (fr == 1) m_irq[1] = v;
            else if (fr == 2) begin
                if (!v) begin m_req = 1'b1; set = 1'b1; end
            end else if (fr == 16) begin
                if (!v) m_chk = 1'b1;
            end else if (fr >= 17) m_pci[fr-17] = v;
            else if (fr >= 3 && fr != 8 && fr != 13 && fr != 14) m_irq[fr] = v;
        end
        if (set) m_sts = 1'b1;
        else if (smi_sts_clr) m_sts = 1'b0;
        if (md >= 0) m_mode = md[0];
    endtask

    task automatic send_cycle(input int slen, input logic [20:0] fr, input int stop_len);
        logic prev1;
        int   md;
        prev1 = m_irq[1];
        for (int i = 0; i < slen; i++) tick(1'b0, -1, -1);
        for (int c = 0; c <= 64; c++) begin
            bit s;
            int idx;
            s   = (c >= 2) && (((c - 2) % 3) == 0);
            idx = (c - 2) / 3;
            if (s) tick(fr[idx], idx, -1);
            else tick(1'b1, -1, -1);
            if (c == 4) begin
                @(negedge clk);
                check(kbd_irq1_n === prev1, "R2 frame 2 not yet captured", 32'(kbd_irq1_n), 32'(prev1));
            end
            if (c == 5) begin
                @(negedge clk);
                check(kbd_irq1_n === fr[1], "R2 frame 2 captured at clock 5", 32'(kbd_irq1_n), 32'(fr[1]));
            end
            if (c == 8 && !fr[2]) begin
                @(negedge clk);
                check(smi_sts === 1'b1, "R5 status set", 32'(smi_sts), 32'h1);
            end
        end
        for (int i = 0; i < stop_len; i++) tick(1'b0, -1, -1);
        md = (stop_len == 2) ? 0 : ((stop_len == 3) ? 1 : -1);
        tick(1'b1, -1, md);
        tick(1'b1, -1, -1);
        tick(1'b1, -1, -1);
    endtask

    task automatic bad_start(input int len);
        for (int i = 0; i < len; i++) tick(1'b0, -1, -1);
        for (int i = 0; i < 8; i++) tick(1'b1, -1, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [20:0] fa, fb;
        logic [15:0] snap_irq;
        logic [3:0]  snap_pci;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq_n === 16'hFFFF, "R10 reset irq_n", 32'(irq_n), 32'hFFFF);
        check(pci_int_n === 4'hF, "R10 reset pci_int_n", 32'(pci_int_n), 32'hF);
        check({smi_req, smi_sts, iochk_evt} === 3'b000, "R10 reset events",
              32'({smi_req, smi_sts, iochk_evt}), 32'h0);
        check(cont_mode === 1'b1, "R10 reset mode", 32'(cont_mode), 32'h1);
        @(posedge clk);
        #1 rst = 1'b0;
        cmp_on = 1'b1;
        tick(1'b1, -1, -1);
        tick(1'b1, -1, -1);

        // Cycle A: shortest start, lows on live, ignored and event slots, quiet stop
        fa = '1;
        fa[0] = 1'b0; fa[1] = 1'b0; fa[2] = 1'b0; fa[5] = 1'b0; fa[8] = 1'b0;
        fa[12] = 1'b0; fa[13] = 1'b0; fa[14] = 1'b0; fa[16] = 1'b0; fa[18] = 1'b0;
        send_cycle(4, fa, 2);
        @(negedge clk);
        check({irq_n[14], irq_n[13], irq_n[8], irq_n[0]} === 4'hF, "R4 ignored slots",
              32'({irq_n[14], irq_n[13], irq_n[8], irq_n[0]}), 32'hF);
        check({irq_n[12], irq_n[5], irq_n[1]} === 3'b000, "R3 live slots low",
              32'({irq_n[12], irq_n[5], irq_n[1]}), 32'h0);
        check(pci_int_n === 4'b1101, "R3 pin B", 32'(pci_int_n), 32'hD);
        check(cont_mode === 1'b0, "R9 quiet", 32'(cont_mode), 32'h0);
        check(smi_sts === 1'b1, "R5 sticky", 32'(smi_sts), 32'h1);

        smi_sts_clr = 1'b1;
        tick(1'b1, -1, -1);
        smi_sts_clr = 1'b0;
        @(negedge clk);
        check(smi_sts === 1'b0, "R5 cleared", 32'(smi_sts), 32'h0);

        // Rejected start lengths
        snap_irq = irq_n;
        snap_pci = pci_int_n;
        bad_start(3);
        bad_start(9);
        @(negedge clk);
        check(irq_n === snap_irq, "R1 short/long start ignored", 32'(irq_n), 32'(snap_irq));
        check(pci_int_n === snap_pci, "R1 short/long start ignored pci", 32'(pci_int_n), 32'(snap_pci));

        // Cycle B: longest start, internal lows, clear held through SMI capture, continuous stop
        int_irq_n[5] = 1'b0; int_irq_n[2] = 1'b0; int_irq_n[13] = 1'b0; int_irq_n[12] = 1'b0;
        int_pci_n[0] = 1'b0;
        smi_sts_clr = 1'b1;
        fb = '1;
        fb[2] = 1'b0; fb[3] = 1'b0; fb[10] = 1'b0; fb[15] = 1'b0; fb[20] = 1'b0; fb[16] = 1'b1;
        send_cycle(8, fb, 3);
        smi_sts_clr = 1'b0;
        @(negedge clk);
        check(irq_n[5] === 1'b0, "R7 internal low wins", 32'(irq_n[5]), 32'h0);
        check({irq_n[13], irq_n[2]} === 2'b00, "R4 internal-only lines", 32'({irq_n[13], irq_n[2]}), 32'h0);
        check(pci_int_n === 4'b0110, "R7 pci merge", 32'(pci_int_n), 32'h6);
        check({kbd_irq12_n, irq_n[12]} === 2'b10, "R8 raw vs merged", 32'({kbd_irq12_n, irq_n[12]}), 32'h2);
        check({irq_n[15], irq_n[10], irq_n[3]} === 3'b000, "R3 upper slots", 32'({irq_n[15], irq_n[10], irq_n[3]}), 32'h0);
        check(cont_mode === 1'b1, "R9 continuous", 32'(cont_mode), 32'h1);

        // Cycle C: all high, one-clock stop leaves mode alone
        int_irq_n = '1;
        int_pci_n = '1;
        send_cycle(6, '1, 1);
        for (int i = 0; i < 10; i++) tick(1'b1, -1, -1);
        @(negedge clk);
        check(irq_n === 16'hFFFF, "R10 levels held high", 32'(irq_n), 32'hFFFF);
        check(cont_mode === 1'b1, "R9 unchanged on 1-clock stop", 32'(cont_mode), 32'h1);

        // Cycles D and E: quiet, then unchanged; levels held between them
        send_cycle(5, fa, 2);
        send_cycle(7, fa, 1);
        @(negedge clk);
        check(cont_mode === 1'b0, "R9 stays quiet", 32'(cont_mode), 32'h0);
        check(iochk_evt === 1'b0, "R6 event gone", 32'(iochk_evt), 32'h0);
        check(irq_n[1] === 1'b0, "R10 level held across cycles", 32'(irq_n[1]), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule